// File: doc/BRIEF.md
# Abstract Register Access Sequencer

This block carries out one debug command that reaches the registers of a halted processor core. The debugger writes a 32-bit command word. The block decodes the word and then runs up to three steps in a fixed order. First it can move data between an argument register (arg0) and one core register, in either direction. Then it can add one to the register number held in the command. Finally it can ask for a single run of a program buffer. The first step that fails stops the sequence, and the block records an error code.

The core register file and the program-buffer engine sit outside the block. Each is reached through a simple hold-until-acknowledged handshake. The debugger loads arg0 while the block is idle, and it reads arg0, the command word held by the block and the error field straight from output ports. Register widths come from parameters: general-purpose and control registers are XLEN bits, floating-point registers are FLEN bits, and arg0 is ARG_W bits.

Top module: `dbg_regaccess_seq`

## Requirements
- R1: After reset, busy, cmd_err, arg0, cmd_echo, rf_req and pb_start are all zero.
- R2: A cmd_wr pulse is accepted only while busy is low and cmd_err is zero. When it is accepted, busy is high from the next cycle until the sequence ends. A cmd_wr that arrives while busy is high, or while cmd_err is non-zero, is ignored: cmd_echo, arg0 and the register file stay unchanged.
- R3: The command word has these fields: type in [31:24], size in [22:20], post-increment in bit 19, post-execute in bit 18, transfer in bit 17, write in bit 16 and register number in [15:0]. A type other than 0 sets cmd_err to 2 and no step runs. With transfer set, a size code below 2, or an access width 8<<size above ARG_W, also sets cmd_err to 2 and no step runs. Size code 2 means 32 bits, 3 means 64 bits and 4 means 128 bits.
- R4: The register number selects a group. 0x0000–0x0fff are control registers (XLEN bits), 0x1000–0x101f are general-purpose registers (XLEN bits), 0x1020–0x103f are floating-point registers (FLEN bits), and 0xc000–0xffff are non-standard registers (XLEN bits). Any other number with transfer set gives cmd_err 3 and no register-file request.
- R5: With transfer set, an access width larger than the width of the register's group gives cmd_err 3, and no register-file request is made.
- R6: A read (transfer 1, write 0) loads arg0 with the low access-width bits of rf_rdata. The bits of arg0 above that width become zero.
- R7: A write (transfer 1, write 1) drives rf_wdata with the low access-width bits of arg0, and the upper bits are zero. arg0 is left unchanged.
- R8: If the register file answers with rf_fault, cmd_err becomes 3. No increment follows, and the program buffer does not run.
- R9: With post-increment set, the register number in cmd_echo goes up by one after a successful transfer, and 0xffff wraps to 0x0000.
- R10: With post-execute set and no earlier failure, pb_start is raised exactly once, after any transfer. pb_start and rf_req are never high together.
- R11: If the program buffer completes with pb_exc, cmd_err becomes 3.
- R12: An err_clr pulse while busy is low sets cmd_err back to zero.
- R13: With transfer clear, no register-file request is made and arg0 stays unchanged, whatever the size and register-number fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| err_clr | input | 1 | Clear the error field |
| arg_wr | input | 1 | Debugger write strobe for arg0 |
| arg_wdata | input | ARG_W | Value written into arg0 |
| arg0 | output | ARG_W | Argument data register |
| cmd_echo | output | 32 | Command word held by the block, including the incremented register number |
| busy | output | 1 | Sequence in progress |
| cmd_err | output | 3 | Error code: 0 none, 2 not supported, 3 exception |
| rf_req | output | 1 | Register-file request, held until rf_ack |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | 16 | Register number |
| rf_size | output | 3 | Size code of the access |
| rf_wdata | output | ARG_W | Write data, masked to the access width |
| rf_rdata | input | ARG_W | Read data |
| rf_ack | input | 1 | Register-file acknowledge |
| rf_fault | input | 1 | Register does not exist; valid together with rf_ack |
| pb_start | output | 1 | Program-buffer run request, held until pb_done |
| pb_done | input | 1 | Program-buffer run finished |
| pb_exc | input | 1 | Program buffer raised an exception; valid together with pb_done |

## Verification
The command is registered on the edge where cmd_wr is sampled, so busy is due one cycle later. A decode error shows up in cmd_err on the next edge, and no request is raised. A register-file request is raised two cycles after acceptance, and arg0, the register number and cmd_err change on the edge where rf_ack is sampled. The bench samples busy exactly one cycle after the strobe. It then waits for busy to fall, up to a fixed bound, and compares arg0, cmd_echo, cmd_err, the register model and the request and program-buffer counters with values worked out from the command fields.

// File: rtl/dbgacc_pkg.sv
// Shared types for the abstract register access sequencer.
// Assumes the command field positions listed in R3.
package dbgacc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_XFER  = 2'd2,
        ST_EXEC  = 2'd3
    } seq_state_e;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_EXC   = 3'd3;

    typedef struct packed {
        logic [7:0]  ctype;
        logic        rsv;
        logic [2:0]  size;
        logic        pinc;
        logic        pexec;
        logic        xfer;
        logic        wr;
        logic [15:0] regno;
    } acc_cmd_t;

endpackage

// File: rtl/dbgacc_decode.sv
// Pure combinational check of a held command: register group, width
// limits and the access-width mask. Assumes the command is stable while busy.
module dbgacc_decode
    import dbgacc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int FLEN  = 64,
    parameter int ARG_W = 64
) (
    input  acc_cmd_t           cmd,
    output logic [2:0]         pre_err,
    output logic [ARG_W-1:0]   acc_mask
);
    localparam logic [31:0] XLEN_U  = 32'(XLEN);
    localparam logic [31:0] FLEN_U  = 32'(FLEN);
    localparam logic [31:0] ARGW_U  = 32'(ARG_W);

    logic [31:0] acc_bits;
    logic [31:0] grp_w;
    logic        grp_ok;

    // Width of the requested access in bits.
    assign acc_bits = 32'd8 << cmd.size;

    // Map the register number onto a group and its width.
    always_comb begin
        grp_ok = 1'b1;
        grp_w  = XLEN_U;
        if (cmd.regno <= 16'h0fff) begin
            grp_w = XLEN_U;
        end else if (cmd.regno <= 16'h101f) begin
            grp_w = XLEN_U;
        end else if (cmd.regno <= 16'h103f) begin
            grp_w = FLEN_U;
        end else if (cmd.regno >= 16'hc000) begin
            grp_w = XLEN_U;
        end else begin
            grp_ok = 1'b0;
        end
    end

    // Rank the decode failures: type, then size support, then the register.
    always_comb begin
        pre_err = ERR_NONE;
        if (cmd.ctype != 8'd0) begin
            pre_err = ERR_UNSUP;
        end else if (cmd.xfer) begin
            if (cmd.size < 3'd2 || acc_bits > ARGW_U) begin
                pre_err = ERR_UNSUP;
            end else if (!grp_ok || acc_bits > grp_w) begin
                pre_err = ERR_EXC;
            end
        end
    end

    // One mask bit per arg0 bit, set below the access width.
    for (genvar gi = 0; gi < ARG_W; gi++) begin : g_mask
        assign acc_mask[gi] = (32'(gi) < acc_bits);
    end

endmodule

// File: rtl/dbgacc_argreg.sv
// arg0 storage. A register read loads masked data; otherwise the
// debugger may write it. Assumes the top gates host writes with busy.
module dbgacc_argreg #(
    parameter int ARG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [ARG_W-1:0] host_data,
    input  logic             ld,
    input  logic [ARG_W-1:0] ld_data,
    input  logic [ARG_W-1:0] mask,
    output logic [ARG_W-1:0] arg_q
);
    // Hold arg0; a read result takes priority over a debugger write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0;
        end else if (ld) begin
            arg_q <= ld_data & mask;
        end else if (host_wr) begin
            arg_q <= host_data;
        end
    end

    AST_ARG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !host_wr) |=> $stable(arg_q)); // R7

endmodule

// File: rtl/dbgacc_fsm.sv
// Sequencer: accept, check, transfer (with post-increment), then the
// program-buffer run. The first failure records an error and ends the run.
// Assumes rf_fault and pb_exc are only meaningful along with their acks.
module dbgacc_fsm
    import dbgacc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_word,
    input  logic        err_clr,
    input  logic [2:0]  pre_err,
    input  logic        rf_ack,
    input  logic        rf_fault,
    input  logic        pb_done,
    input  logic        pb_exc,
    output acc_cmd_t    cmd_q,
    output logic [2:0]  err_q,
    output logic        busy,
    output logic        rf_req,
    output logic        pb_start,
    output logic        arg_ld
);
    seq_state_e state;

    // Step through the sequence and record the command and any error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cmd_q <= '0;
            err_q <= ERR_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (err_clr) begin
                        err_q <= ERR_NONE;
                    end else if (cmd_wr && err_q == ERR_NONE) begin
                        cmd_q <= acc_cmd_t'(cmd_word);
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (pre_err != ERR_NONE) begin
                        err_q <= pre_err;
                        state <= ST_IDLE;
                    end else if (cmd_q.xfer) begin
                        state <= ST_XFER;
                    end else if (cmd_q.pexec) begin
                        state <= ST_EXEC;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_XFER: begin
                    if (rf_ack) begin
                        if (rf_fault) begin
                            err_q <= ERR_EXC;
                            state <= ST_IDLE;
                        end else begin
                            if (cmd_q.pinc) begin
                                cmd_q.regno <= cmd_q.regno + 16'd1;
                            end
                            state <= cmd_q.pexec ? ST_EXEC : ST_IDLE;
                        end
                    end
                end
                ST_EXEC: begin
                    if (pb_done) begin
                        if (pb_exc) begin
                            err_q <= ERR_EXC;
                        end
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Handshake requests follow the state directly.
    assign busy     = (state != ST_IDLE);
    assign rf_req   = (state == ST_XFER);
    assign pb_start = (state == ST_EXEC);
    assign arg_ld   = (state == ST_XFER) && rf_ack && !rf_fault && !cmd_q.wr;

    AST_REQ_NEEDS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> (busy && cmd_q.xfer)); // R13
    AST_EXEC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        pb_start |-> (!rf_req && cmd_q.pexec)); // R10
    AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != ERR_NONE && $past(err_q) == ERR_NONE) |-> (state == ST_IDLE)); // R8
    AST_REGNO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && cmd_q.regno != $past(cmd_q.regno))
            |-> (cmd_q.regno == $past(cmd_q.regno) + 16'd1)); // R9
    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && err_q != ERR_NONE && !err_clr) |=> (state == ST_IDLE)); // R2

endmodule

// File: rtl/dbg_regaccess_seq.sv
// Top of the abstract register access sequencer. Ties the decode, the
// sequencer and arg0 storage together. Assumes a halted core behind the
// register-file port and a single program-buffer engine.
module dbg_regaccess_seq
    import dbgacc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int FLEN  = 64,
    parameter int ARG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_word,
    input  logic             err_clr,
    input  logic             arg_wr,
    input  logic [ARG_W-1:0] arg_wdata,
    output logic [ARG_W-1:0] arg0,
    output logic [31:0]      cmd_echo,
    output logic             busy,
    output logic [2:0]       cmd_err,
    output logic             rf_req,
    output logic             rf_we,
    output logic [15:0]      rf_addr,
    output logic [2:0]       rf_size,
    output logic [ARG_W-1:0] rf_wdata,
    input  logic [ARG_W-1:0] rf_rdata,
    input  logic             rf_ack,
    input  logic             rf_fault,
    output logic             pb_start,
    input  logic             pb_done,
    input  logic             pb_exc
);
    acc_cmd_t         cmd_q;
    logic [2:0]       pre_err;
    logic [ARG_W-1:0] acc_mask;
    logic             arg_ld;

    dbgacc_decode #(.XLEN(XLEN), .FLEN(FLEN), .ARG_W(ARG_W)) u_decode (
        .cmd      (cmd_q),
        .pre_err  (pre_err),
        .acc_mask (acc_mask)
    );

    dbgacc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .err_clr  (err_clr),
        .pre_err  (pre_err),
        .rf_ack   (rf_ack),
        .rf_fault (rf_fault),
        .pb_done  (pb_done),
        .pb_exc   (pb_exc),
        .cmd_q    (cmd_q),
        .err_q    (cmd_err),
        .busy     (busy),
        .rf_req   (rf_req),
        .pb_start (pb_start),
        .arg_ld   (arg_ld)
    );

    dbgacc_argreg #(.ARG_W(ARG_W)) u_arg (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (arg_wr && !busy),
        .host_data (arg_wdata),
        .ld        (arg_ld),
        .ld_data   (rf_rdata),
        .mask      (acc_mask),
        .arg_q     (arg0)
    );

    // Register-file port fields come from the held command.
    assign cmd_echo = cmd_q;
    assign rf_we    = cmd_q.wr;
    assign rf_addr  = cmd_q.regno;
    assign rf_size  = cmd_q.size;
    assign rf_wdata = arg0 & acc_mask;

    AST_REQ_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && $past(rf_req)) |-> ($stable(rf_addr) && $stable(rf_we))); // R4

endmodule

// File: tb/dbg_regaccess_seq_tb.sv
module dbg_regaccess_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ARG_W = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [31:0]      cmd_word = '0;
    logic             err_clr = 1'b0;
    logic             arg_wr = 1'b0;
    logic [ARG_W-1:0] arg_wdata = '0;
    logic [ARG_W-1:0] arg0;
    logic [31:0]      cmd_echo;
    logic             busy;
    logic [2:0]       cmd_err;
    logic             rf_req, rf_we;
    logic [15:0]      rf_addr;
    logic [2:0]       rf_size;
    logic [ARG_W-1:0] rf_wdata;
    logic [ARG_W-1:0] rf_rdata = '0;
    logic             rf_ack = 1'b0, rf_fault = 1'b0;
    logic             pb_start;
    logic             pb_done = 1'b0, pb_exc = 1'b0;

    int errors = 0;
    int checks = 0;
    int rf_cnt = 0;
    int pb_cnt = 0;
    logic pb_fail_mode = 1'b0;

    logic [31:0] gpr [32];
    logic [63:0] fpr [32];
    logic [31:0] csr [16];
    logic [31:0] cst_lo, cst_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_regaccess_seq #(.XLEN(32), .FLEN(64), .ARG_W(ARG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .err_clr(err_clr), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .arg0(arg0), .cmd_echo(cmd_echo), .busy(busy), .cmd_err(cmd_err),
        .rf_req(rf_req), .rf_we(rf_we), .rf_addr(rf_addr), .rf_size(rf_size),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .rf_ack(rf_ack),
        .rf_fault(rf_fault), .pb_start(pb_start), .pb_done(pb_done),
        .pb_exc(pb_exc)
    );

    function automatic bit reg_exists(input logic [15:0] a);
        return (a >= 16'h1000 && a <= 16'h103f) || (a >= 16'h0300 && a <= 16'h030f)
            || a == 16'hc000 || a == 16'hffff;
    endfunction

    function automatic int grp_width(input logic [15:0] a);
        if (a <= 16'h101f) return 32;
        if (a <= 16'h103f) return 64;
        if (a >= 16'hc000) return 32;
        return 0;
    endfunction

    function automatic logic [63:0] reg_read(input logic [15:0] a);
        if (a >= 16'h1000 && a <= 16'h101f) return {32'd0, gpr[a[4:0]]};
        if (a >= 16'h1020 && a <= 16'h103f) return fpr[a[4:0]];
        if (a >= 16'h0300 && a <= 16'h030f) return {32'd0, csr[a[3:0]]};
        if (a == 16'hc000) return {32'd0, cst_lo};
        if (a == 16'hffff) return {32'd0, cst_hi};
        return 64'd0;
    endfunction

    function automatic logic [63:0] width_mask(input int bits);
        if (bits >= 64) return '1;
        return (64'd1 << bits) - 64'd1;
    endfunction

    // Register-file model: one-cycle acknowledge.
    always @(negedge clk) begin
        if (rf_ack) begin
            rf_ack = 1'b0;
            rf_fault = 1'b0;
        end else if (rf_req) begin
            rf_cnt++;
            rf_ack = 1'b1;
            rf_fault = !reg_exists(rf_addr);
            rf_rdata = reg_read(rf_addr);
            if (rf_we && reg_exists(rf_addr)) begin
                if (rf_addr >= 16'h1000 && rf_addr <= 16'h101f) gpr[rf_addr[4:0]] = rf_wdata[31:0];
                else if (rf_addr >= 16'h1020 && rf_addr <= 16'h103f) fpr[rf_addr[4:0]] = rf_wdata;
                else if (rf_addr >= 16'h0300 && rf_addr <= 16'h030f) csr[rf_addr[3:0]] = rf_wdata[31:0];
                else if (rf_addr == 16'hc000) cst_lo = rf_wdata[31:0];
                else cst_hi = rf_wdata[31:0];
            end
        end
    end

    // Program-buffer model: one-cycle completion.
    always @(negedge clk) begin
        if (pb_done) begin
            pb_done = 1'b0;
            pb_exc = 1'b0;
        end else if (pb_start) begin
            pb_cnt++;
            pb_done = 1'b1;
            pb_exc = pb_fail_mode;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_arg(input logic [63:0] v);
        @(negedge clk);
        arg_wr = 1'b1; arg_wdata = v;
        @(negedge clk);
        arg_wr = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    // Issue one command and compare every outcome with the expected one.
    task automatic run_cmd(input logic [7:0] ctype, input logic [2:0] size,
                           input logic pinc, input logic pexec, input logic xfer,
                           input logic wr, input logic [15:0] regno,
                           input logic pbfail, input logic [63:0] pat);
        int accb, gw, e_err, rf0, pb0;
        bit pre_ok, rf_ok;
        logic [63:0] mask, old_reg, e_arg;
        logic [15:0] e_regno;
        accb = 8 << size;
        gw = grp_width(regno);
        mask = width_mask(accb);
        pre_ok = 1'b0;
        if (ctype != 0) e_err = 2;
        else if (xfer && (size < 2 || accb > ARG_W)) e_err = 2;
        else if (xfer && (gw == 0 || accb > gw)) e_err = 3;
        else begin e_err = 0; pre_ok = 1'b1; end
        rf_ok = pre_ok && xfer && reg_exists(regno);
        if (pre_ok && xfer && !reg_exists(regno)) e_err = 3;
        if (pre_ok && (!xfer || rf_ok) && pexec && pbfail) e_err = 3;
        e_regno = (rf_ok && pinc) ? regno + 16'd1 : regno;
        e_arg = (rf_ok && !wr) ? (reg_read(regno) & mask) : pat;
        old_reg = reg_read(regno);
        set_arg(pat);
        pb_fail_mode = pbfail;
        rf0 = rf_cnt; pb0 = pb_cnt;
        cmd_word = {ctype, 1'b0, size, pinc, pexec, xfer, wr, regno};
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R2 busy one cycle after accept", {63'd0, busy}, 64'd1);
        wait_idle();
        check("R3 R4 R5 R8 R11 error code", {61'd0, cmd_err}, 64'(e_err));
        check("R6 R7 R13 arg0", arg0, e_arg);
        check("R9 register number", {48'd0, cmd_echo[15:0]}, {48'd0, e_regno});
        check("R4 R5 R13 register-file requests", 64'(rf_cnt - rf0),
              64'((pre_ok && xfer) ? 1 : 0));
        check("R10 R8 program-buffer runs", 64'(pb_cnt - pb0),
              64'((pre_ok && pexec && (!xfer || rf_ok)) ? 1 : 0));
        if (rf_ok && wr) check("R7 register written", reg_read(regno), pat & mask);
        else check("R7 register untouched", reg_read(regno), old_reg);
        if (cmd_err != 3'd0) clear_err();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] regs [13];
        int seed;
        regs = '{16'h1000, 16'h1007, 16'h101f, 16'h1020, 16'h103f, 16'h0300,
                 16'h030f, 16'h0000, 16'h0fff, 16'h1040, 16'hbfff, 16'hc000, 16'hffff};
        for (int i = 0; i < 32; i++) begin
            gpr[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
            fpr[i] = {32'hf00d_0000 + 32'(i), 32'h8765_4321 ^ 32'(i)};
        end
        for (int i = 0; i < 16; i++) csr[i] = 32'h3000_0000 | 32'(i);
        cst_lo = 32'hc0c0_c0c0;
        cst_hi = 32'hffff_0001;
        seed = 1;
        repeat (4) @(negedge clk);
        check("R1 busy after reset", {63'd0, busy}, 64'd0);
        check("R1 error after reset", {61'd0, cmd_err}, 64'd0);
        check("R1 arg0 after reset", arg0, 64'd0);
        check("R1 cmd_echo after reset", {32'd0, cmd_echo}, 64'd0);
        check("R1 handshakes after reset", {62'd0, rf_req, pb_start}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep register numbers, sizes, directions and options.
        for (int r = 0; r < 13; r++)
            for (int s = 0; s < 6; s++)
                for (int w = 0; w < 2; w++)
                    for (int o = 0; o < 4; o++) begin
                        seed++;
                        run_cmd(8'd0, 3'(s), o[0], o[1], 1'b1, w[0], regs[r], 1'b0,
                                {32'(seed) * 32'h9e37_79b9, 32'(seed) ^ 32'hdead_beef});
                    end
        // R13: no transfer, garbage fields, with and without the buffer.
        for (int s = 0; s < 8; s++)
            for (int o = 0; o < 4; o++)
                run_cmd(8'd0, 3'(s), 1'b1, o[0], 1'b0, o[1], 16'h7777, 1'b0,
                        64'h0123_4567_89ab_cdef + 64'(s));
        // R11: program-buffer exception after a good transfer and alone.
        run_cmd(8'd0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 16'h1003, 1'b1, 64'h55);
        run_cmd(8'd0, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1003, 1'b1, 64'h66);
        // R3: other command types.
        for (int t = 1; t < 4; t++)
            run_cmd(8'(t), 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1001, 1'b0, 64'h77);

        // R2: a second command while busy is ignored.
        @(negedge clk);
        cmd_word = {8'd0, 1'b0, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1004};
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_word = {8'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1009};
        @(negedge clk);
        cmd_wr = 1'b0;
        wait_idle();
        @(negedge clk);
        check("R2 command while busy ignored", {48'd0, cmd_echo[15:0]}, 64'h1004);
        check("R2 busy-time command no access", {32'd0, gpr[9]}, {32'd0, 32'h1000_0000 + 32'd9 * 32'h0101_0101});

        // R2/R12: commands blocked while an error is pending.
        run_cmd(8'd5, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1002, 1'b0, 64'h88);
        @(negedge clk);
        cmd_word = {8'd9, 24'd0};
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_word = {8'd0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1002};
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R2 busy stays low while error pending", {63'd0, busy}, 64'd0);
        check("R2 cmd_echo unchanged while error pending", {32'd0, cmd_echo}, {32'd0, 8'd9, 24'd0});
        check("R12 error held before clear", {61'd0, cmd_err}, 64'd2);
        clear_err();
        check("R12 error cleared", {61'd0, cmd_err}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule